// File: doc/BRIEF.md
# Read-Triggered Context Sample Register

This block holds a 32-bit snapshot of the active context identifier for a program-counter profiling unit. The snapshot is not written by anyone. It is loaded as a side effect: whenever the external debugger reads the low word of the companion program-counter sample register, the companion logic pulses a trigger. On that clock edge the block copies the live context identifier into its sample register. The processor keeps two banked copies of the identifier, one for secure and one for non-secure state. The copy taken is the one that belongs to the security state recorded with that program-counter sample.

A debugger reads the snapshot over a simple memory-mapped debug bus. The bus has an address, read and write strobes, read data, an acknowledge and an error flag. The register answers at two mirrored offsets, 0x208 and 0x228, and both follow the same rules. A read is granted only when the core is powered and neither the double lock nor the OS lock is set. A read refused by those conditions, any write and any access to an unmapped address all get an error response.

The snapshot survives warm reset and debug reset and is cleared only by a cold reset. When the block is built without the sampling feature, a granted read returns zero.

Top module: `ctx_sample_reg`

## Requirements
- R1: While the cold reset `coldRstN` is low, `dbgAck`, `dbgErr` and `dbgRdata` are 0. The snapshot is forced to 0, so the first granted read after cold reset returns 0.
- R2: When `pcSampleRd` is high at a rising clock edge, the snapshot takes `ctxIdNs` if `pcSampleNs` is 1, and `ctxIdSec` if `pcSampleNs` is 0. With `pcSampleRd` low, the snapshot keeps its value.
- R3: A read is granted when `dbgRd` is high, `dbgWr` is low, the address is mapped, `corePowered` is 1, `dblLock` is 0 and `osLock` is 0. After the edge that samples the read, `dbgAck` is 1, `dbgErr` is 0 and `dbgRdata` holds the snapshot.
- R4: Offsets 0x208 and 0x228 are both mapped and return the same snapshot under the same rules.
- R5: A read to a mapped offset while `corePowered` is 0, `dblLock` is 1 or `osLock` is 1 gets `dbgAck`=1 and `dbgErr`=1 one cycle later, with `dbgRdata`=0.
- R6: A write (`dbgWr` high) to either offset gets `dbgErr`=1 and `dbgRdata`=0 one cycle later and leaves the snapshot unchanged.
- R7: A read of any unmapped address, for example 0x20C or 0x000, gets `dbgErr`=1 and `dbgRdata`=0 one cycle later.
- R8: When a granted read and a capture trigger share a clock edge, the read returns the snapshot held before that capture.
- R9: Pulsing `warmRstN` or `dbgRstN` low leaves the snapshot unchanged. A later granted read returns the value captured before the pulse.
- R10: In a cycle after an edge with no bus access, `dbgAck` and `dbgErr` are 0 and `dbgRdata` is 0.
- R11: When the block is built with `SAMPLE_IMPL`=0, a granted read returns 0 with `dbgErr`=0. Error responses are the same as in the full build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Cold reset, asynchronous, active low; clears snapshot and response |
| warmRstN | input | 1 | Warm reset, active low; clears only the bus response |
| dbgRstN | input | 1 | External debug reset, active low; clears only the bus response |
| dbgAddr | input | 12 | Debug bus byte address |
| dbgRd | input | 1 | Read strobe, one cycle per access |
| dbgWr | input | 1 | Write strobe, one cycle per access |
| dbgRdata | output | 32 | Registered read data, zero on error or idle |
| dbgAck | output | 1 | Registered response valid, one cycle after a strobe |
| dbgErr | output | 1 | Registered error response |
| pcSampleRd | input | 1 | Pulse: the low word of the PC sample register is being read |
| pcSampleNs | input | 1 | Security state recorded with that PC sample, 1 = non-secure |
| ctxIdSec | input | 32 | Live secure-bank context identifier |
| ctxIdNs | input | 32 | Live non-secure-bank context identifier |
| corePowered | input | 1 | Core power domain is up |
| dblLock | input | 1 | Double lock is set |
| osLock | input | 1 | OS lock is set |

## Verification
The hardest case to reach from the ports is a capture and a read of the snapshot landing on the same clock edge. Only there can a read-before-write mistake show. The bench's bus task can raise the capture trigger in the same cycle as a read strobe. It computes the expected read value from the model before it updates the model with the new bank. It also changes both banked inputs between captures, so a wrong bank choice shows up as a visible mismatch. Warm and debug reset pulses are placed between a capture and a read, so a snapshot lost to the wrong reset domain cannot hide.

// File: rtl/ctx_samp_pkg.sv
package ctx_samp_pkg;
  // Strobes from the access controller to the sample datapath
  typedef struct packed {
    logic capture;   // load snapshot from the selected bank
    logic access;    // any bus strobe this cycle
    logic rdGrant;   // read permitted, return snapshot
    logic fault;     // respond with error
  } ctxStrobe_t;
endpackage

// File: rtl/ctx_samp_ctrl.sv
module ctx_samp_ctrl
  import ctx_samp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MIRROR_CNT = 2,
  parameter logic [MIRROR_CNT*ADDR_W-1:0] MIRROR_OFFS = {12'h228, 12'h208}
) (
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgRd,
  input  logic              dbgWr,
  input  logic              pcSampleRd,
  input  logic              corePowered,
  input  logic              dblLock,
  input  logic              osLock,
  output ctxStrobe_t        strb
);
  logic [MIRROR_CNT-1:0] hitVec;
  logic addrHit;
  logic accessOk;

  // one comparator per mirrored offset
  for (genvar m = 0; m < MIRROR_CNT; m++) begin : g_mirror
    assign hitVec[m] = (dbgAddr == MIRROR_OFFS[m*ADDR_W +: ADDR_W]);
  end

  assign addrHit  = |hitVec;
  assign accessOk = corePowered & ~dblLock & ~osLock;

  always_comb begin
    strb.capture = pcSampleRd;
    strb.access  = dbgRd | dbgWr;
    strb.rdGrant = dbgRd & ~dbgWr & addrHit & accessOk;
    strb.fault   = (dbgRd | dbgWr) & ~strb.rdGrant;
  end
endmodule

// File: rtl/ctx_samp_dp.sv
module ctx_samp_dp
  import ctx_samp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit SAMPLE_IMPL = 1'b1
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRstN,
  input  logic              dbgRstN,
  input  ctxStrobe_t        strb,
  input  logic              pcSampleNs,
  input  logic [DATA_W-1:0] ctxIdSec,
  input  logic [DATA_W-1:0] ctxIdNs,
  output logic [DATA_W-1:0] sampleQ,
  output logic [DATA_W-1:0] dbgRdata,
  output logic              dbgAck,
  output logic              dbgErr
);
  logic [DATA_W-1:0] liveCtx;
  logic [DATA_W-1:0] readVal;
  logic              respClr;

  assign liveCtx = pcSampleNs ? ctxIdNs : ctxIdSec;
  assign respClr = ~warmRstN | ~dbgRstN;

  // snapshot: only the cold reset reaches it
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)          sampleQ <= '0;
    else if (strb.capture)  sampleQ <= liveCtx;
  end

  if (SAMPLE_IMPL) begin : g_impl
    assign readVal = sampleQ;
  end else begin : g_noimpl
    assign readVal = '0;
  end

  // registered response; the read sees sampleQ before this edge's capture
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      dbgRdata <= '0;
      dbgAck   <= 1'b0;
      dbgErr   <= 1'b0;
    end else if (respClr) begin
      dbgRdata <= '0;
      dbgAck   <= 1'b0;
      dbgErr   <= 1'b0;
    end else begin
      dbgRdata <= strb.rdGrant ? readVal : '0;
      dbgAck   <= strb.access;
      dbgErr   <= strb.fault;
    end
  end
endmodule

// File: rtl/ctx_sample_reg.sv
module ctx_sample_reg
  import ctx_samp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int MIRROR_CNT = 2,
  parameter logic [MIRROR_CNT*ADDR_W-1:0] MIRROR_OFFS = {12'h228, 12'h208},
  parameter bit SAMPLE_IMPL = 1'b1
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRstN,
  input  logic              dbgRstN,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgRd,
  input  logic              dbgWr,
  output logic [DATA_W-1:0] dbgRdata,
  output logic              dbgAck,
  output logic              dbgErr,
  input  logic              pcSampleRd,
  input  logic              pcSampleNs,
  input  logic [DATA_W-1:0] ctxIdSec,
  input  logic [DATA_W-1:0] ctxIdNs,
  input  logic              corePowered,
  input  logic              dblLock,
  input  logic              osLock
);
  ctxStrobe_t        strb;
  logic [DATA_W-1:0] sampleQ;

  ctx_samp_ctrl #(
    .ADDR_W(ADDR_W), .MIRROR_CNT(MIRROR_CNT), .MIRROR_OFFS(MIRROR_OFFS)
  ) u_ctrl (
    .dbgAddr(dbgAddr), .dbgRd(dbgRd), .dbgWr(dbgWr), .pcSampleRd(pcSampleRd),
    .corePowered(corePowered), .dblLock(dblLock), .osLock(osLock), .strb(strb)
  );

  ctx_samp_dp #(
    .DATA_W(DATA_W), .SAMPLE_IMPL(SAMPLE_IMPL)
  ) u_dp (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN), .dbgRstN(dbgRstN),
    .strb(strb), .pcSampleNs(pcSampleNs), .ctxIdSec(ctxIdSec), .ctxIdNs(ctxIdNs),
    .sampleQ(sampleQ), .dbgRdata(dbgRdata), .dbgAck(dbgAck), .dbgErr(dbgErr)
  );
endmodule

// File: rtl/ctx_sample_reg_chk.sv
module ctx_sample_reg_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int MIRROR_CNT = 2,
  parameter logic [MIRROR_CNT*ADDR_W-1:0] MIRROR_OFFS = {12'h228, 12'h208},
  parameter bit SAMPLE_IMPL = 1'b1
) (
  input logic              clk,
  input logic              coldRstN,
  input logic              warmRstN,
  input logic              dbgRstN,
  input logic [ADDR_W-1:0] dbgAddr,
  input logic              dbgRd,
  input logic              dbgWr,
  input logic [DATA_W-1:0] dbgRdata,
  input logic              dbgAck,
  input logic              dbgErr,
  input logic              pcSampleRd,
  input logic              pcSampleNs,
  input logic [DATA_W-1:0] ctxIdSec,
  input logic [DATA_W-1:0] ctxIdNs,
  input logic              corePowered,
  input logic              dblLock,
  input logic              osLock,
  input logic [DATA_W-1:0] sampleQ
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int m = 0; m < MIRROR_CNT; m++)
      if (dbgAddr == MIRROR_OFFS[m*ADDR_W +: ADDR_W]) mapped = 1'b1;
  end

  a_r2_capture_bank: assert property (@(posedge clk) disable iff (!coldRstN)
    pcSampleRd |=> sampleQ == ($past(pcSampleNs) ? $past(ctxIdNs) : $past(ctxIdSec)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!coldRstN)
    !pcSampleRd |=> $stable(sampleQ));

  a_r3_grant: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN || !dbgRstN)
    (dbgRd && !dbgWr && mapped && corePowered && !dblLock && !osLock)
      |=> dbgAck && !dbgErr && dbgRdata == (SAMPLE_IMPL ? $past(sampleQ) : '0));

  a_r5_gate: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN || !dbgRstN)
    (dbgRd && mapped && !(corePowered && !dblLock && !osLock)) |=> dbgAck && dbgErr);

  a_r6_write_err: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN || !dbgRstN)
    dbgWr |=> dbgAck && dbgErr && dbgRdata == '0);

  a_r7_unmapped: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN || !dbgRstN)
    (dbgRd && !mapped) |=> dbgErr);

  a_r10_idle: assert property (@(posedge clk) disable iff (!coldRstN)
    !dbgAck |-> !dbgErr && dbgRdata == '0);
endmodule

bind ctx_sample_reg ctx_sample_reg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MIRROR_CNT(MIRROR_CNT),
  .MIRROR_OFFS(MIRROR_OFFS), .SAMPLE_IMPL(SAMPLE_IMPL)
) u_chk (
  .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN), .dbgRstN(dbgRstN),
  .dbgAddr(dbgAddr), .dbgRd(dbgRd), .dbgWr(dbgWr), .dbgRdata(dbgRdata),
  .dbgAck(dbgAck), .dbgErr(dbgErr), .pcSampleRd(pcSampleRd), .pcSampleNs(pcSampleNs),
  .ctxIdSec(ctxIdSec), .ctxIdNs(ctxIdNs), .corePowered(corePowered),
  .dblLock(dblLock), .osLock(osLock), .sampleQ(sampleQ)
);

// File: tb/ctx_sample_reg_tb.sv
module ctx_sample_reg_tb;
  logic        clk = 1'b0;
  logic        coldRstN = 1'b0, warmRstN = 1'b1, dbgRstN = 1'b1;
  logic [11:0] dbgAddr = '0;
  logic        dbgRd = 1'b0, dbgWr = 1'b0;
  logic [31:0] dbgRdata, dbgRdataOff;
  logic        dbgAck, dbgErr, dbgAckOff, dbgErrOff;
  logic        pcSampleRd = 1'b0, pcSampleNs = 1'b0;
  logic [31:0] ctxIdSec = '0, ctxIdNs = '0;
  logic        corePowered = 1'b1, dblLock = 1'b0, osLock = 1'b0;

  int checks = 0, errors = 0;
  logic [31:0] model = '0;

  typedef struct { logic err; logic [31:0] data; string tag; } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  ctx_sample_reg u_dut (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN), .dbgRstN(dbgRstN),
    .dbgAddr(dbgAddr), .dbgRd(dbgRd), .dbgWr(dbgWr), .dbgRdata(dbgRdata),
    .dbgAck(dbgAck), .dbgErr(dbgErr), .pcSampleRd(pcSampleRd), .pcSampleNs(pcSampleNs),
    .ctxIdSec(ctxIdSec), .ctxIdNs(ctxIdNs), .corePowered(corePowered),
    .dblLock(dblLock), .osLock(osLock));

  ctx_sample_reg #(.SAMPLE_IMPL(1'b0)) u_dutOff (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN), .dbgRstN(dbgRstN),
    .dbgAddr(dbgAddr), .dbgRd(dbgRd), .dbgWr(dbgWr), .dbgRdata(dbgRdataOff),
    .dbgAck(dbgAckOff), .dbgErr(dbgErrOff), .pcSampleRd(pcSampleRd), .pcSampleNs(pcSampleNs),
    .ctxIdSec(ctxIdSec), .ctxIdNs(ctxIdNs), .corePowered(corePowered),
    .dblLock(dblLock), .osLock(osLock));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle, optional capture on the same edge
  task automatic busCycle(input bit rd, input bit wr, input logic [11:0] addr,
                          input bit cap, input bit ns, input string tag);
    bit hit, ok;
    expItem_t it;
    @(negedge clk);
    hit = (addr == 12'h208) || (addr == 12'h228);
    ok  = rd && !wr && hit && corePowered && !dblLock && !osLock;
    it.err = !ok; it.data = ok ? model : 32'h0; it.tag = tag;
    if (rd || wr) expQ.push_back(it);
    dbgRd = rd; dbgWr = wr; dbgAddr = addr;
    pcSampleRd = cap; pcSampleNs = ns;
    if (cap) model = ns ? ctxIdNs : ctxIdSec;
    @(negedge clk);
    dbgRd = 1'b0; dbgWr = 1'b0; pcSampleRd = 1'b0;
  endtask

  // Monitor: compare every response against the scoreboard
  always @(posedge clk) begin
    #2;
    if (coldRstN && dbgAck) begin
      if (expQ.size() == 0) check(1'b0, "R10 unexpected ack", 1, 0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        check(dbgErr == e.err, {e.tag, " err"}, dbgErr, e.err);
        check(dbgRdata == e.data, {e.tag, " data"}, dbgRdata, e.data);
        check(dbgErrOff == e.err && dbgRdataOff == 32'h0, "R11 no-impl build",
              {dbgErrOff, dbgRdataOff}, {e.err, 32'h0});
      end
    end
  end

  initial begin
    #(8 * 50000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs quiet during cold reset
    repeat (3) @(negedge clk);
    check(dbgAck == 0 && dbgErr == 0 && dbgRdata == 0, "R1 reset outputs",
          {dbgAck, dbgErr, dbgRdata}, 0);
    coldRstN = 1'b1;
    busCycle(1, 0, 12'h208, 0, 0, "R1 snapshot zero after cold reset");

    // R2/R3/R4: capture banks and read both mirrors
    ctxIdNs = 32'hA5A5_0001; ctxIdSec = 32'h5EC0_0001;
    busCycle(0, 0, 12'h000, 1, 1, "R2 capture ns");
    busCycle(1, 0, 12'h208, 0, 0, "R2 R3 ns bank at 0x208");
    busCycle(1, 0, 12'h228, 0, 0, "R4 mirror 0x228");
    ctxIdNs = 32'hA5A5_0002; ctxIdSec = 32'h5EC0_0002;
    busCycle(0, 0, 12'h000, 1, 0, "R2 capture secure");
    busCycle(1, 0, 12'h228, 0, 0, "R2 secure bank");

    // R8: read and capture on the same edge
    ctxIdNs = 32'hCAFE_0003; ctxIdSec = 32'hBEEF_0003;
    busCycle(1, 0, 12'h208, 1, 1, "R8 read sees old value");
    busCycle(1, 0, 12'h208, 0, 0, "R8 new value afterwards");

    // R10: idle cycle
    @(negedge clk); @(negedge clk);
    check(dbgAck == 0 && dbgErr == 0 && dbgRdata == 0, "R10 idle outputs",
          {dbgAck, dbgErr, dbgRdata}, 0);

    // R5: gating
    corePowered = 1'b0; busCycle(1, 0, 12'h208, 0, 0, "R5 core off"); corePowered = 1'b1;
    dblLock = 1'b1;     busCycle(1, 0, 12'h228, 0, 0, "R5 double lock"); dblLock = 1'b0;
    osLock = 1'b1;      busCycle(1, 0, 12'h208, 0, 0, "R5 os lock"); osLock = 1'b0;

    // R6: writes ignored
    busCycle(0, 1, 12'h208, 0, 0, "R6 write 0x208");
    busCycle(0, 1, 12'h228, 0, 0, "R6 write 0x228");
    busCycle(1, 0, 12'h208, 0, 0, "R6 snapshot unchanged");

    // R7: unmapped
    busCycle(1, 0, 12'h20C, 0, 0, "R7 unmapped 0x20C");
    busCycle(1, 0, 12'h000, 0, 0, "R7 unmapped 0x000");

    // R9: warm and debug reset keep the snapshot
    @(negedge clk); warmRstN = 1'b0; @(negedge clk); warmRstN = 1'b1;
    busCycle(1, 0, 12'h228, 0, 0, "R9 after warm reset");
    @(negedge clk); dbgRstN = 1'b0; @(negedge clk); dbgRstN = 1'b1;
    busCycle(1, 0, 12'h208, 0, 0, "R9 after debug reset");

    // R1: cold reset in mid-run clears the snapshot
    @(negedge clk); coldRstN = 1'b0; model = '0;
    @(negedge clk); coldRstN = 1'b1;
    busCycle(1, 0, 12'h228, 0, 0, "R1 cleared by cold reset");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all responses seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule